// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block generates pulse-width-modulated outputs from one shared counter and several compare channels. The counter advances only on a clock-enable tick. In single-slope (fast) mode it counts from zero up to a programmable ceiling and wraps back to zero. In dual-slope mode it counts up to the ceiling, stays there for one tick, and then counts back down to zero. Because this waveform is symmetric about its peak, dual-slope mode suits motor drives.

Each channel has its own compare value and a 2-bit output mode, and it drives a true pin and a complementary pin. For each pin a direction bit decides whether the waveform logic drives it. When the waveform logic does not drive a pin, the pin shows a general-purpose port value. In dual-slope mode, writes to the ceiling and compare registers are staged and take effect only when the counter returns to zero, so a running period is never broken. Software programs the block through a simple write port. All pins are registered and change one clock after the counter value they reflect.

Top module: `pwm_tmr`

## Requirements
- R1: While rst_ni is low, and after it is released, count_o is 0, the counter direction is up, and every pin_o bit is 0.
- R2: In fast mode (address 0 bits[2:1] not 01, or bit0 clear), each tick moves count_o from 0 up to TOP (address 2) and then back to 0.
- R3: Dual-slope mode is selected by address 0 bit0 = 1 together with bits[2:1] = 01. In this mode the counter climbs by one per tick to TOP, holds TOP for exactly one tick, descends to 0 and repeats. Without a tick the counter does not change.
- R4: Mode 10 in dual-slope drives both of the channel's pins. The true pin (pin_o bit 2c for channel c) is high while count < compare (address 8+c) and low otherwise. The complementary pin (bit 2c+1) is always its inverse.
- R5: Mode 11 in dual-slope is the inverse of R4. The true pin is low while count < compare, and the complementary pin is its inverse.
- R6: Mode 01 in dual-slope sets the true pin at BOTTOM and clears it on the up-count match. The pin is therefore high only on up-counting ticks with count < compare, and low from the match until the counter returns to 0. Both pins are driven.
- R7: In fast mode, modes 10 and 11 use a level that is high while count < compare. Mode 10 drives only the true pin, with this level. Mode 11 drives only the complementary pin, with the inverse of this level. The other pin of the channel shows its port bit.
- R8: In fast mode, mode 01 drives both pins and toggles the waveform on every tick where the new count equals compare. With TOP = 3 this gives a 50% duty square wave of period 8 ticks.
- R9: A compare value of 0 (with TOP > 0) gives a constant low level. A compare value at or above TOP gives a constant high level. Each channel's polarity (R4, R5, R7) is applied to this level.
- R10: A pin shows its port bit (address 3, bit per pin) when its channel mode is 00, when the mode leaves it undriven, or when its direction bit (address 4) is 0.
- R11: In dual-slope mode, writes to TOP and to the compare registers take effect only on the tick where the counter reaches 0. In fast mode they take effect one clock after the write. Channel modes are at address 1, in bits [2c+1:2c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | CNT_W | Register write data |
| count_o | output | CNT_W | Current counter value |
| pin_o | output | 2*N_CH | Pin outputs: true pin at bit 2c, complementary pin at bit 2c+1 |

## Verification
The bench follows the dual-slope turnaround and checks that TOP is seen once per peak. A counter that dwelt two ticks at TOP, or that missed a step at zero, would shift every later count. The complementary mode is checked on the down slope: a design that set the pin on the down-count match, instead of waiting for BOTTOM, would raise it too early. Compare values of zero, equal to TOP and above TOP must give flat outputs, so a design that let a one-tick spike through at the peak is caught. A TOP and compare rewrite is made in the middle of a dual-slope period. The bench then expects the old peak and the old duty to continue until zero, which exposes any design that loads the new values at once.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'b00,
    CH_ALT  = 2'b01,
    CH_NORM = 2'b10,
    CH_INV  = 2'b11
  } ch_mode_e;

  localparam logic [1:0] WAVE_DUAL = 2'b01;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MODE = 1;
  localparam int ADDR_TOP  = 2;
  localparam int ADDR_PORT = 3;
  localparam int ADDR_DIR  = 4;
  localparam int ADDR_CMP0 = 8;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_CH   = 2,
  parameter int ADDR_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [CNT_W-1:0]            wr_data_i,
  input  logic                        load_i,
  output logic                        dual_o,
  output logic [N_CH-1:0][1:0]        mode_o,
  output logic [CNT_W-1:0]            top_o,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [2*N_CH-1:0]           port_o,
  output logic [2*N_CH-1:0]           dir_o
);
  localparam int PIN_N = 2 * N_CH;

  logic [2:0]                   ctrl_q;
  logic [CNT_W-1:0]             top_buf_q;
  logic [N_CH-1:0][CNT_W-1:0]   cmp_buf_q;

  assign dual_o = ctrl_q[0] && (ctrl_q[2:1] == WAVE_DUAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      mode_o    <= '0;
      port_o    <= '0;
      dir_o     <= '0;
      top_buf_q <= '0;
      cmp_buf_q <= '0;
      top_o     <= '0;
      cmp_o     <= '0;
    end else begin
      if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(ADDR_CTRL)) ctrl_q    <= wr_data_i[2:0];
        if (wr_addr_i == ADDR_W'(ADDR_MODE)) mode_o    <= wr_data_i[PIN_N-1:0];
        if (wr_addr_i == ADDR_W'(ADDR_TOP))  top_buf_q <= wr_data_i;
        if (wr_addr_i == ADDR_W'(ADDR_PORT)) port_o    <= wr_data_i[PIN_N-1:0];
        if (wr_addr_i == ADDR_W'(ADDR_DIR))  dir_o     <= wr_data_i[PIN_N-1:0];
        for (int c = 0; c < N_CH; c++) begin
          if (wr_addr_i == ADDR_W'(ADDR_CMP0 + c)) cmp_buf_q[c] <= wr_data_i;
        end
      end
      // dual-slope: active values change only at BOTTOM
      if (!dual_o || load_i) begin
        top_o <= top_buf_q;
        cmp_o <= cmp_buf_q;
      end
    end
  end

  a_r11_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_o && !load_i) |=> (top_o == $past(top_o)));

  a_r11_hold_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_o && !load_i) |=> (cmp_o == $past(cmp_o)));
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             up_o,
  output logic             load_o
);
  localparam int CW1 = CNT_W + 1;

  logic up_nxt;

  always_comb begin
    cnt_nxt_o = cnt_o;
    up_nxt    = up_o;
    if (tick_i) begin
      if (!dual_i) begin
        up_nxt    = 1'b1;
        cnt_nxt_o = (cnt_o >= top_i) ? '0 : cnt_o + CNT_W'(1);
      end else if (up_o) begin
        if (({1'b0, cnt_o} + CW1'(1)) >= {1'b0, top_i}) begin
          cnt_nxt_o = top_i;
          up_nxt    = 1'b0;
        end else begin
          cnt_nxt_o = cnt_o + CNT_W'(1);
        end
      end else begin
        if (cnt_o <= CNT_W'(1)) begin
          cnt_nxt_o = '0;
          up_nxt    = 1'b1;
        end else begin
          cnt_nxt_o = cnt_o - CNT_W'(1);
        end
      end
    end
  end

  assign load_o = tick_i && dual_i && (cnt_nxt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      up_o  <= 1'b1;
    end else begin
      cnt_o <= cnt_nxt_o;
      up_o  <= up_nxt;
    end
  end

  a_r2_fast_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dual_i && cnt_o >= top_i) |=> (cnt_o == '0));

  a_r3_descend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dual_i && !up_o && cnt_o > CNT_W'(1)) |=>
      (cnt_o == $past(cnt_o) - CNT_W'(1)));

  a_r3_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dual_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             up_i,
  output logic             wave_o,
  output logic [1:0]       drv_o
);
  logic tog_q;
  logic full, below, lvl;

  assign full  = (cmp_i >= top_i);
  assign below = (cnt_i < cmp_i);
  assign lvl   = full | below;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (tick_i && (cnt_nxt_i == cmp_i)) tog_q <= ~tog_q;
  end

  always_comb begin
    wave_o = 1'b0;
    unique case (mode_i)
      CH_NORM: wave_o = lvl;
      CH_INV:  wave_o = dual_i ? ~lvl : lvl;
      CH_ALT:  wave_o = dual_i ? (full | (up_i & below)) : tog_q;
      default: wave_o = 1'b0;
    endcase
  end

  // drv_o[0]: true pin, drv_o[1]: complementary pin
  always_comb begin
    if (dual_i) drv_o = {2{mode_i != CH_OFF}};
    else begin
      unique case (mode_i)
        CH_ALT:  drv_o = 2'b11;
        CH_NORM: drv_o = 2'b01;
        CH_INV:  drv_o = 2'b10;
        default: drv_o = 2'b00;
      endcase
    end
  end

  a_r8_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dual_i && mode_i == CH_ALT && cnt_nxt_i == cmp_i) |=>
      (tog_q != $past(tog_q)));
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_CH   = 2,
  parameter int ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [2*N_CH-1:0]   pin_o
);
  localparam int PIN_N = 2 * N_CH;

  logic                        dual, load, up;
  logic [N_CH-1:0][1:0]        mode;
  logic [CNT_W-1:0]            top, cnt_nxt;
  logic [N_CH-1:0][CNT_W-1:0]  cmp;
  logic [PIN_N-1:0]            port, dir, pin_val, pin_drv;
  logic [N_CH-1:0]             wave;
  logic [N_CH-1:0][1:0]        drv;

  pwm_tmr_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .load_i(load), .dual_o(dual), .mode_o(mode),
    .top_o(top), .cmp_o(cmp), .port_o(port), .dir_o(dir)
  );

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .dual_i(dual), .top_i(top),
    .cnt_o(count_o), .cnt_nxt_o(cnt_nxt), .up_o(up), .load_o(load)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .dual_i(dual),
      .mode_i(mode[c]), .cmp_i(cmp[c]), .top_i(top), .cnt_i(count_o),
      .cnt_nxt_i(cnt_nxt), .up_i(up), .wave_o(wave[c]), .drv_o(drv[c])
    );
    assign pin_val[2*c]   = wave[c];
    assign pin_val[2*c+1] = ~wave[c];
    assign pin_drv[2*c]   = drv[c][0];
    assign pin_drv[2*c+1] = drv[c][1];

    a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode[c] == CH_OFF) |=> (pin_o[2*c+1 -: 2] == $past(port[2*c+1 -: 2])));

    a_r9_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode[c] == CH_NORM && cmp[c] == '0 && top != '0 && dir[2*c]) |=> !pin_o[2*c]);

    a_r9_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode[c] == CH_NORM && cmp[c] >= top && dir[2*c]) |=> pin_o[2*c]);

    a_r5_pair_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dual && mode[c] == CH_INV && dir[2*c] && dir[2*c+1]) |=> (pin_o[2*c] != pin_o[2*c+1]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= '0;
    else         pin_o <= (dir & pin_drv & pin_val) | (~(dir & pin_drv) & port);
  end
endmodule

// File: tb/tb_pwm_tmr.sv
`timescale 1ns/1ps
module tb_pwm_tmr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] count_o;
  logic [3:0] pin_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pwm_tmr dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = 8'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic step();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  function automatic int dcnt(input int k, input int t);
    int p = k % (2 * t);
    return (p <= t) ? p : 2 * t - p;
  endfunction

  function automatic bit dup(input int k, input int t);
    return (k % (2 * t)) < t;
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 count after reset", count_o, 0);
    chk("R1 pins after reset", pin_o, 0);
    wr(2, 3); wr(1, 8'h0A); wr(4, 8'h0F); wr(0, 3);
    idle(3);
    step(); step();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 count during reset", count_o, 0);
    chk("R1 pins during reset", pin_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_release();
    do_reset();
    // ch0 dual NORM cmp 2, dir bit0 off; ch1 mode off
    wr(2, 3); wr(8, 2); wr(1, 8'h02); wr(3, 8'h09); wr(4, 8'h0E); wr(0, 3);
    idle(3);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] e;
      if (k > 0) step();
      e[0] = 1'b1;
      e[1] = !(dcnt(k, 3) < 2);
      e[2] = 1'b0;
      e[3] = 1'b1;
      chk("R10 pin release by dir and mode", pin_o, e);
    end
  endtask

  task automatic t_fast();
    do_reset();
    // ch0 NORM cmp 2, ch1 INV cmp 1, TOP 3, fast mode
    wr(2, 3); wr(8, 2); wr(9, 1); wr(1, 8'h0E); wr(3, 8'h02); wr(4, 8'h0F);
    idle(3);
    for (int k = 0; k < 10; k++) begin
      logic [3:0] e;
      int c;
      if (k > 0) step();
      c = k % 4;
      chk("R2 fast count", count_o, c);
      e[0] = (c < 2);
      e[1] = 1'b1;
      e[2] = 1'b0;
      e[3] = !(c < 1);
      chk("R7 fast single-pin levels", pin_o, e);
    end
  endtask

  task automatic t_toggle();
    int highs = 0;
    do_reset();
    wr(2, 3); wr(8, 1); wr(1, 8'h01); wr(4, 8'h0F);
    idle(3);
    chk("R8 toggle initial", pin_o, 4'b0010);
    for (int k = 1; k <= 12; k++) begin
      bit t;
      step();
      t = ((k + 3) / 4) % 2;
      chk("R8 toggle pins", pin_o, {2'b00, !t, t});
      if (k > 4 && pin_o[0]) highs++;
    end
    chk("R8 duty over 8 ticks", highs, 4);
  endtask

  task automatic t_dual_levels();
    do_reset();
    // ch0 NORM cmp 2, ch1 INV cmp 2, dual TOP 3
    wr(2, 3); wr(8, 2); wr(9, 2); wr(1, 8'h0E); wr(4, 8'h0F); wr(0, 3);
    idle(3);
    for (int k = 0; k < 14; k++) begin
      int c;
      if (k > 0) step();
      c = dcnt(k, 3);
      chk("R3 dual count", count_o, c);
      chk("R4 dual non-inverting pair", pin_o[1:0], (c < 2) ? 1 : 2);
      chk("R5 dual inverting pair", pin_o[3:2], (c < 2) ? 2 : 1);
    end
  endtask

  task automatic t_dual_alt();
    do_reset();
    // ch0 ALT cmp 2, ch1 ALT cmp 0
    wr(2, 3); wr(8, 2); wr(9, 0); wr(1, 8'h05); wr(4, 8'h0F); wr(0, 3);
    idle(3);
    for (int k = 0; k < 14; k++) begin
      bit h;
      if (k > 0) step();
      h = dup(k, 3) && (dcnt(k, 3) < 2);
      chk("R6 complementary mode true/comp", pin_o[1:0], h ? 1 : 2);
      chk("R9 compare zero low", pin_o[3:2], 2);
    end
  endtask

  task automatic t_const();
    do_reset();
    // ch0 NORM cmp 5 (>TOP), ch1 INV cmp 3 (=TOP)
    wr(2, 3); wr(8, 5); wr(9, 3); wr(1, 8'h0E); wr(4, 8'h0F); wr(0, 3);
    idle(3);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) step();
      chk("R9 constant outputs at or above TOP", pin_o, 4'b1001);
    end
  endtask

  task automatic t_buffer();
    int exp_c[10] = '{3, 2, 1, 0, 1, 2, 3, 4, 5, 4};
    int exp_p[10] = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 0};
    do_reset();
    wr(2, 3); wr(8, 1); wr(1, 8'h02); wr(4, 8'h0F); wr(0, 3);
    idle(3);
    step(); step();
    chk("R11 count before rewrite", count_o, 2);
    wr(2, 5); wr(8, 4);
    idle(2);
    chk("R11 old compare kept mid-period", pin_o[0], 0);
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R11 staged TOP count", count_o, exp_c[i]);
      chk("R11 staged compare pin", pin_o[0], exp_p[i]);
    end
  endtask

  task automatic t_tick_gate();
    do_reset();
    wr(2, 3); wr(0, 3);
    idle(2);
    step();
    idle(6);
    chk("R3 no advance without tick", count_o, 1);
    step();
    chk("R3 advance on tick", count_o, 2);
  endtask

  initial begin
    t_reset();
    t_release();
    t_fast();
    t_toggle();
    t_dual_levels();
    t_dual_alt();
    t_const();
    t_buffer();
    t_tick_gate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule